// File: doc/BRIEF.md
# Interrupt Context Stacking Sequencer

This block moves the processor's working context between the register file and a byte-wide stack memory when an interrupt is taken and when the service routine returns. On entry it takes a snapshot of the return address, the two index registers, both accumulators and the condition-code byte. It writes them to the stack as a nine-byte frame, one byte per clock, and the stack pointer moves down by one before each write. When the frame is complete it raises the interrupt-mask bits in the condition-code value it hands back to the core and asks for the vector fetch.

On a return request it reads the same nine bytes back, one per clock, in the opposite order, and the stack pointer moves up by one after each read. It then presents the recovered registers. The condition-code byte is handed back exactly as it was stored, so both mask bits return to the state they had before the interrupt.

Entry starts only at an instruction boundary, so the instruction in flight always completes first. An entry request that arrives while a frame is being moved is remembered and served as soon as the sequencer is free again. The core can load the stack pointer while the sequencer is idle.

Top module: `ctx_stack_seq`

## Requirements
- R1: After reset, `busy`, `done`, `vec_req`, `ctx_load`, `ccr_load`, `mem_we` and `mem_re` are 0, and `sp` equals the parameter SP_INIT (default 16'h3C80).
- R2: An entry request is accepted only in a clock where `insn_boundary` is 1 and the sequencer is idle. The first stack write happens in the clock after acceptance. A request made while `insn_boundary` is 0 stays pending and produces no memory access.
- R3: An entry performs exactly nine consecutive write cycles. With SP0 the stack pointer before entry, write k (k = 0..8) goes to address SP0-1-k and carries, for k = 0 to 8: return address bits [7:0], return address bits [15:8], Y[7:0], Y[15:8], X[7:0], X[15:8], accumulator A, accumulator B, condition codes.
- R4: When an entry completes, `sp` equals SP0-9, which is the address that holds the condition-code byte.
- R5: In the clock after the ninth write, `done`, `vec_req` and `ccr_load` are 1 for one cycle. For a maskable entry, `ccr_out` equals the saved condition codes with bit 4 (I) forced to 1 and every other bit unchanged.
- R6: For a non-maskable entry (`entry_nmi` = 1 with the request), `ccr_out` at completion has both bit 4 (I) and bit 6 (X) forced to 1. All other bits come from the saved byte.
- R7: A return performs exactly nine consecutive read cycles. Read k goes to address SP0+k, where SP0 is the stack pointer at acceptance. The bytes are taken in the reverse of the R3 order: condition codes first, return address bits [7:0] last.
- R8: In the clock after the ninth read, `done`, `ctx_load` and `ccr_load` are 1 and `vec_req` is 0. `ccr_out` equals the pulled condition-code byte unmodified, so I and X may come back cleared. `out_pc`, `out_y`, `out_x`, `out_a` and `out_b` hold the pulled values. `sp` equals SP0+9.
- R9: An entry request that arrives while a sequence is running is held. It is accepted in the first idle clock with `insn_boundary` = 1, so its `done` comes 11 clocks after the earlier `done` when the boundary is held high.
- R10: The frame contents come from the register inputs in the acceptance clock. Later changes to those inputs do not alter the bytes written.
- R11: In any clock at most one of `mem_we` and `mem_re` is 1. A `sp_load` pulse while `busy` is 1 is ignored.
- R12: A `sp_load` pulse while idle sets `sp` to `sp_load_val` in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_boundary | input | 1 | Current instruction has completed |
| entry_req | input | 1 | Interrupt entry request (pulse or level) |
| entry_nmi | input | 1 | Entry request is non-maskable |
| ret_req | input | 1 | Return-from-interrupt request |
| cur_pc | input | 16 | Address of the next instruction of the interrupted program |
| cur_y | input | 16 | Index register Y |
| cur_x | input | 16 | Index register X |
| cur_a | input | 8 | Accumulator A |
| cur_b | input | 8 | Accumulator B |
| cur_ccr | input | 8 | Condition-code byte |
| sp_load | input | 1 | Load the stack pointer (idle only) |
| sp_load_val | input | ADDR_W | Stack pointer load value |
| sp | output | ADDR_W | Current stack pointer |
| mem_addr | output | ADDR_W | Stack memory address |
| mem_we | output | 1 | Stack memory write strobe |
| mem_re | output | 1 | Stack memory read strobe |
| mem_wdata | output | 8 | Stack memory write byte |
| mem_rdata | input | 8 | Stack memory read byte, valid in the same clock as `mem_re` |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| vec_req | output | 1 | Vector fetch request, with `done` of an entry |
| ccr_load | output | 1 | Core should load `ccr_out` |
| ccr_out | output | 8 | New condition-code byte |
| ctx_load | output | 1 | Core should load the restored registers |
| out_pc | output | 16 | Restored return address |
| out_y | output | 16 | Restored Y |
| out_x | output | 16 | Restored X |
| out_a | output | 8 | Restored accumulator A |
| out_b | output | 8 | Restored accumulator B |

## Verification
The hardest situation to reach from the ports is a second entry that arrives in the middle of a frame write, together with a stack-pointer load and changed register inputs. Hitting it needs a request pulse timed inside the nine write cycles. The stimulus places that pulse a few clocks into a directed entry. It then checks that the first frame still holds the snapshot, that the pointer load has no effect, and that the second frame starts exactly one idle clock after the first finishes. Nested entries followed by unwinding returns are also mixed into the seeded random runs, so frames stack on top of each other and are unwound in order.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

  localparam int FRAME_LEN = 9;
  localparam int IDX_W     = 4;
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(FRAME_LEN - 1);

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PUSH = 2'd1,
    SQ_PULL = 2'd2,
    SQ_DONE = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [15:0] ret_pc;
    logic [15:0] idx_y;
    logic [15:0] idx_x;
    logic [7:0]  acc_a;
    logic [7:0]  acc_b;
    logic [7:0]  ccr;
  } cpu_ctx_t;

  // Byte stored by the push with the given slot number (0 is pushed first).
  function automatic logic [7:0] frame_byte(cpu_ctx_t c, logic [IDX_W-1:0] slot);
    logic [7:0] b;
    case (slot)
      4'd0:    b = c.ret_pc[7:0];
      4'd1:    b = c.ret_pc[15:8];
      4'd2:    b = c.idx_y[7:0];
      4'd3:    b = c.idx_y[15:8];
      4'd4:    b = c.idx_x[7:0];
      4'd5:    b = c.idx_x[15:8];
      4'd6:    b = c.acc_a;
      4'd7:    b = c.acc_b;
      default: b = c.ccr;
    endcase
    return b;
  endfunction

  // Place a pulled byte back into the field that owns the given push slot.
  function automatic cpu_ctx_t frame_merge(cpu_ctx_t c, logic [IDX_W-1:0] slot,
                                           logic [7:0] d);
    cpu_ctx_t r;
    r = c;
    case (slot)
      4'd0:    r.ret_pc[7:0]  = d;
      4'd1:    r.ret_pc[15:8] = d;
      4'd2:    r.idx_y[7:0]   = d;
      4'd3:    r.idx_y[15:8]  = d;
      4'd4:    r.idx_x[7:0]   = d;
      4'd5:    r.idx_x[15:8]  = d;
      4'd6:    r.acc_a        = d;
      4'd7:    r.acc_b        = d;
      default: r.ccr          = d;
    endcase
    return r;
  endfunction

  // The n-th pull reads the byte of the push slot counted from the top.
  function automatic logic [IDX_W-1:0] pull_slot(logic [IDX_W-1:0] n);
    return LAST_SLOT - n;
  endfunction

  // Condition codes handed to the core when an entry completes.
  function automatic logic [7:0] entry_mask(logic [7:0] ccr, logic nmi,
                                            int i_pos, int x_pos);
    logic [7:0] m;
    m = ccr;
    m[i_pos] = 1'b1;
    if (nmi) m[x_pos] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/ctx_req_gate.sv
module ctx_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic entry_req,
  input  logic entry_nmi,
  input  logic ret_req,
  input  logic insn_boundary,
  input  logic seq_idle,
  output logic start_entry,
  output logic start_nmi,
  output logic start_ret
);
  logic pend_q, pend_nmi_q;
  logic entry_seen;

  assign entry_seen  = pend_q | entry_req;
  assign start_entry = seq_idle & insn_boundary & entry_seen;
  assign start_nmi   = pend_nmi_q | (entry_req & entry_nmi);
  // An entry, waiting or new, takes precedence over a return.
  assign start_ret   = seq_idle & ret_req & ~entry_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_nmi_q <= 1'b0;
    end else if (start_entry) begin
      pend_q     <= 1'b0;
      pend_nmi_q <= 1'b0;
    end else if (entry_req) begin
      pend_q     <= 1'b1;
      pend_nmi_q <= pend_nmi_q | entry_nmi;
    end
  end

  // R9: a request that could not start is still waiting one clock later
  a_r9_request_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_req && !start_entry) |=> pend_q);

endmodule

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
  import ctx_stack_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_entry,
  input  logic             start_ret,
  output seq_state_e       state,
  output logic [IDX_W-1:0] xfer_idx,
  output logic             push_act,
  output logic             pull_act,
  output logic             fin,
  output logic             fin_entry
);
  localparam logic [IDX_W:0] FULL_CNT = (IDX_W+1)'(FRAME_LEN);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             kind_entry_q;
  logic             last_xfer;

  assign last_xfer = (idx_q == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SQ_IDLE;
      idx_q        <= '0;
      kind_entry_q <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          idx_q <= '0;
          if (start_entry) begin
            state_q      <= SQ_PUSH;
            kind_entry_q <= 1'b1;
          end else if (start_ret) begin
            state_q      <= SQ_PULL;
            kind_entry_q <= 1'b0;
          end
        end
        SQ_PUSH, SQ_PULL: begin
          idx_q <= idx_q + 1'b1;
          if (last_xfer) state_q <= SQ_DONE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign state     = state_q;
  assign xfer_idx  = idx_q;
  assign push_act  = (state_q == SQ_PUSH);
  assign pull_act  = (state_q == SQ_PULL);
  assign fin       = (state_q == SQ_DONE);
  assign fin_entry = fin & kind_entry_q;

  // Independent transfer counter used only by the assertion below.
  logic [IDX_W:0] chk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  chk_cnt <= '0;
    else if (state_q == SQ_IDLE) chk_cnt <= '0;
    else if (push_act | pull_act) chk_cnt <= chk_cnt + 1'b1;
  end

  // R3 / R7: every sequence moves exactly nine bytes before completing
  a_r3_nine_xfers: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (chk_cnt == FULL_CNT));

endmodule

// File: rtl/ctx_sp_unit.sv
module ctx_sp_unit #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SP_INIT = 16'h3C80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sp_load,
  input  logic [ADDR_W-1:0] sp_load_val,
  input  logic              seq_idle,
  input  logic              dec,
  input  logic              inc,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] push_addr
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   sp_q <= SP_INIT;
    else if (dec)                 sp_q <= sp_q - ONE;
    else if (inc)                 sp_q <= sp_q + ONE;
    else if (sp_load && seq_idle) sp_q <= sp_load_val;
  end

  assign sp        = sp_q;
  assign push_addr = sp_q - ONE;  // pre-decrement address of the next push

endmodule

// File: rtl/ctx_frame.sv
module ctx_frame
  import ctx_stack_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_entry,
  input  cpu_ctx_t         live_ctx,
  input  logic             pull_act,
  input  logic [IDX_W-1:0] xfer_idx,
  input  logic [7:0]       rdata,
  output cpu_ctx_t         frame,
  output logic [7:0]       push_data
);
  cpu_ctx_t frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           frame_q <= '0;
    else if (start_entry) frame_q <= live_ctx;
    else if (pull_act)    frame_q <= frame_merge(frame_q, pull_slot(xfer_idx), rdata);
  end

  assign frame     = frame_q;
  assign push_data = frame_byte(frame_q, xfer_idx);

endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
  import ctx_stack_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SP_INIT = 16'h3C80,
  parameter int I_POS = 4,
  parameter int X_POS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_boundary,
  input  logic              entry_req,
  input  logic              entry_nmi,
  input  logic              ret_req,
  input  logic [15:0]       cur_pc,
  input  logic [15:0]       cur_y,
  input  logic [15:0]       cur_x,
  input  logic [7:0]        cur_a,
  input  logic [7:0]        cur_b,
  input  logic [7:0]        cur_ccr,
  input  logic              sp_load,
  input  logic [ADDR_W-1:0] sp_load_val,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              vec_req,
  output logic              ccr_load,
  output logic [7:0]        ccr_out,
  output logic              ctx_load,
  output logic [15:0]       out_pc,
  output logic [15:0]       out_y,
  output logic [15:0]       out_x,
  output logic [7:0]        out_a,
  output logic [7:0]        out_b
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // Named internal events
  logic             seq_idle;
  logic             start_entry, start_nmi, start_ret;
  seq_state_e       state;
  logic [IDX_W-1:0] xfer_idx;
  logic             push_act, pull_act, fin, fin_entry;
  logic [ADDR_W-1:0] push_addr;
  cpu_ctx_t         live_ctx, frame;
  logic [7:0]       push_data;
  logic             nmi_q;

  assign seq_idle = (state == SQ_IDLE);

  assign live_ctx = '{ret_pc: cur_pc, idx_y: cur_y, idx_x: cur_x,
                      acc_a: cur_a, acc_b: cur_b, ccr: cur_ccr};

  ctx_req_gate u_gate (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .entry_nmi(entry_nmi),
    .ret_req(ret_req), .insn_boundary(insn_boundary), .seq_idle(seq_idle),
    .start_entry(start_entry), .start_nmi(start_nmi), .start_ret(start_ret)
  );

  ctx_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_entry(start_entry), .start_ret(start_ret),
    .state(state), .xfer_idx(xfer_idx), .push_act(push_act), .pull_act(pull_act),
    .fin(fin), .fin_entry(fin_entry)
  );

  ctx_sp_unit #(.ADDR_W(ADDR_W), .SP_INIT(SP_INIT)) u_sp (
    .clk(clk), .rst_n(rst_n), .sp_load(sp_load), .sp_load_val(sp_load_val),
    .seq_idle(seq_idle), .dec(push_act), .inc(pull_act),
    .sp(sp), .push_addr(push_addr)
  );

  ctx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .start_entry(start_entry), .live_ctx(live_ctx),
    .pull_act(pull_act), .xfer_idx(xfer_idx), .rdata(mem_rdata),
    .frame(frame), .push_data(push_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           nmi_q <= 1'b0;
    else if (start_entry) nmi_q <= start_nmi;
  end

  assign mem_we    = push_act;
  assign mem_re    = pull_act;
  assign mem_addr  = push_act ? push_addr : sp;
  assign mem_wdata = push_data;

  assign busy     = ~seq_idle;
  assign done     = fin;
  assign vec_req  = fin_entry;
  assign ctx_load = fin & ~fin_entry;
  assign ccr_load = fin;
  assign ccr_out  = fin_entry ? entry_mask(frame.ccr, nmi_q, I_POS, X_POS) : frame.ccr;

  assign out_pc = frame.ret_pc;
  assign out_y  = frame.idx_y;
  assign out_x  = frame.idx_x;
  assign out_a  = frame.acc_a;
  assign out_b  = frame.acc_b;

  // R11: never a read and a write in the same clock
  a_r11_one_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}));

  // R3: consecutive pushes walk down one address at a time
  a_r3_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - ONE));

  // R7: consecutive pulls walk up one address at a time
  a_r7_pull_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + ONE));

  // R2: a write burst only begins after a clock with the boundary flag
  a_r2_boundary_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(insn_boundary));

  // R5: an entry always hands back a maskable-blocked condition code
  a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> ccr_out[I_POS]);

  // R6: a non-maskable entry also blocks the non-maskable line
  a_r6_nmi_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && nmi_q) |-> ccr_out[X_POS]);

  // R8: each completion is exactly one of entry or return
  a_r8_done_kind: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vec_req ^ ctx_load));

  // R12 / R11: the pointer moves only for a transfer or an idle load
  a_r12_sp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we && !mem_re && !(sp_load && !busy)) |=> (sp == $past(sp)));

endmodule

// File: tb/tb_ctx_stack_seq.sv
module tb_ctx_stack_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_boundary = 1'b0, entry_req = 1'b0, entry_nmi = 1'b0, ret_req = 1'b0;
  logic [15:0] cur_pc = '0, cur_y = '0, cur_x = '0;
  logic [7:0]  cur_a = '0, cur_b = '0, cur_ccr = '0;
  logic        sp_load = 1'b0;
  logic [15:0] sp_load_val = '0;
  logic [15:0] sp, mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata, mem_rdata, ccr_out, out_a, out_b;
  logic        busy, done, vec_req, ccr_load, ctx_load;
  logic [15:0] out_pc, out_y, out_x;

  always #10 clk = ~clk;  // 50 MHz

  ctx_stack_seq dut (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .entry_req(entry_req),
    .entry_nmi(entry_nmi), .ret_req(ret_req), .cur_pc(cur_pc), .cur_y(cur_y),
    .cur_x(cur_x), .cur_a(cur_a), .cur_b(cur_b), .cur_ccr(cur_ccr),
    .sp_load(sp_load), .sp_load_val(sp_load_val), .sp(sp), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .vec_req(vec_req), .ccr_load(ccr_load),
    .ccr_out(ccr_out), .ctx_load(ctx_load), .out_pc(out_pc), .out_y(out_y),
    .out_x(out_x), .out_a(out_a), .out_b(out_b)
  );

  // Stack memory model and transfer logs
  logic [7:0]  mem [0:255];
  logic [15:0] wa [0:63];
  logic [7:0]  wd [0:63];
  logic [15:0] ra [0:63];
  int wn = 0, rn = 0, both_cnt = 0;
  int n_chk = 0, n_err = 0;

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wa[wn % 64] <= mem_addr;
      wd[wn % 64] <= mem_wdata;
      wn <= wn + 1;
    end
    if (mem_re) begin
      ra[rn % 64] <= mem_addr;
      rn <= rn + 1;
    end
    if (mem_we && mem_re) both_cnt <= both_cnt + 1;
  end

  // Saved frames for nested returns
  logic [15:0] s_pc [0:3], s_y [0:3], s_x [0:3];
  logic [7:0]  s_a [0:3], s_b [0:3], s_c [0:3];
  int sd = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Frame as the bench sees it: byte k of the result is push number k
  function automatic logic [71:0] frame_vec(logic [15:0] pc, logic [15:0] y,
      logic [15:0] x, logic [7:0] a, logic [7:0] b, logic [7:0] c);
    return {c, b, a, x[15:8], x[7:0], y[15:8], y[7:0], pc[15:8], pc[7:0]};
  endfunction

  function automatic logic [7:0] exp_entry_ccr(logic [7:0] c, bit nmi);
    return c | 8'h10 | (nmi ? 8'h40 : 8'h00);
  endfunction

  task automatic set_ctx(input logic [15:0] pc, y, x, input logic [7:0] a, b, c);
    cur_pc = pc; cur_y = y; cur_x = x; cur_a = a; cur_b = b; cur_ccr = c;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 40);
  endtask

  task automatic load_sp(input logic [15:0] v);
    @(negedge clk);
    sp_load = 1'b1; sp_load_val = v;
    @(negedge clk);
    sp_load = 1'b0;
    chk(sp == v, "R12 sp load", sp, v);
  endtask

  // Checks taken in the done clock of an entry
  task automatic check_entry(input logic [15:0] sp0, input int base, input bit nmi);
    logic [71:0] v;
    int k;
    k = sd - 1;
    v = frame_vec(s_pc[k], s_y[k], s_x[k], s_a[k], s_b[k], s_c[k]);
    chk(vec_req && ccr_load && !ctx_load, "R5 entry strobes",
        {vec_req, ccr_load, ctx_load}, 3'b110);
    chk(ccr_out == exp_entry_ccr(s_c[k], nmi), nmi ? "R6 nmi ccr" : "R5 masked ccr",
        ccr_out, exp_entry_ccr(s_c[k], nmi));
    chk(sp == sp0 - 16'd9, "R4 sp after entry", sp, sp0 - 16'd9);
    chk(wn - base == 9, "R3 write count", wn - base, 9);
    for (int j = 0; j < 9; j++) begin
      chk(wa[(base + j) % 64] == sp0 - 16'(1 + j), "R3 push address",
          wa[(base + j) % 64], sp0 - 16'(1 + j));
      chk(wd[(base + j) % 64] == v[8*j +: 8], "R3 R10 push byte",
          wd[(base + j) % 64], v[8*j +: 8]);
    end
    chk(mem[sp[7:0]] == s_c[k], "R4 sp points at ccr", mem[sp[7:0]], s_c[k]);
  endtask

  task automatic push_saved(input logic [15:0] pc, y, x, input logic [7:0] a, b, c);
    s_pc[sd] = pc; s_y[sd] = y; s_x[sd] = x; s_a[sd] = a; s_b[sd] = b; s_c[sd] = c;
    sd++;
  endtask

  task automatic do_entry(input logic [15:0] pc, y, x, input logic [7:0] a, b, c,
                          input bit nmi);
    logic [15:0] sp0;
    int base, n;
    @(negedge clk);
    set_ctx(pc, y, x, a, b, c);
    push_saved(pc, y, x, a, b, c);
    insn_boundary = 1'b1; entry_req = 1'b1; entry_nmi = nmi;
    sp0 = sp; base = wn;
    @(negedge clk);
    entry_req = 1'b0; entry_nmi = 1'b0;
    set_ctx(16'($urandom), 16'($urandom), 16'($urandom), 8'($urandom),
            8'($urandom), 8'($urandom));  // R10: inputs move after acceptance
    chk(busy && mem_we, "R2 write follows acceptance", {busy, mem_we}, 2'b11);
    wait_done(n);
    n++;
    chk(n == 10, "R5 entry latency", n, 10);
    check_entry(sp0, base, nmi);
  endtask

  task automatic do_return();
    logic [15:0] sp0;
    int base, n, k;
    @(negedge clk);
    ret_req = 1'b1; sp0 = sp; base = rn;
    @(negedge clk);
    ret_req = 1'b0;
    wait_done(n);
    n++;
    sd--; k = sd;
    chk(n == 10, "R8 return latency", n, 10);
    chk(ctx_load && ccr_load && !vec_req, "R8 return strobes",
        {ctx_load, ccr_load, vec_req}, 3'b110);
    chk(ccr_out == s_c[k], "R8 ccr restored exactly", ccr_out, s_c[k]);
    chk(out_pc == s_pc[k] && out_y == s_y[k] && out_x == s_x[k],
        "R8 16-bit registers", {out_pc, out_y}, {s_pc[k], s_y[k]});
    chk(out_x == s_x[k], "R8 X restored", out_x, s_x[k]);
    chk(out_a == s_a[k] && out_b == s_b[k], "R8 accumulators",
        {out_a, out_b}, {s_a[k], s_b[k]});
    chk(sp == sp0 + 16'd9, "R8 sp after return", sp, sp0 + 16'd9);
    chk(rn - base == 9, "R7 read count", rn - base, 9);
    for (int j = 0; j < 9; j++)
      chk(ra[(base + j) % 64] == sp0 + 16'(j), "R7 pull address",
          ra[(base + j) % 64], sp0 + 16'(j));
  endtask

  // Global watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int n, base;
    logic [15:0] sp0;
    bit nest, nmi;
    void'($urandom(32'd1357));
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !vec_req && !ctx_load && !ccr_load && !mem_we && !mem_re,
        "R1 reset outputs", {busy, done, vec_req, ctx_load, ccr_load, mem_we, mem_re}, 0);
    chk(sp == 16'h3C80, "R1 reset sp", sp, 16'h3C80);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && sp == 16'h3C80, "R1 idle after reset", {busy, sp}, {1'b0, 16'h3C80});

    load_sp(16'h3CA0);

    // Directed: maskable entry and return, I comes back cleared
    do_entry(16'h1234, 16'h5678, 16'h9ABC, 8'h11, 8'h22, 8'h00, 1'b0);
    do_return();
    // Directed: non-maskable with all other flags set
    do_entry(16'hFEDC, 16'h0102, 16'h0304, 8'hA5, 8'h5A, 8'h8F, 1'b1);
    do_return();

    // R2: request held while the boundary is low
    @(negedge clk);
    set_ctx(16'h4000, 16'h4001, 16'h4002, 8'h40, 8'h41, 8'h42);
    push_saved(16'h4000, 16'h4001, 16'h4002, 8'h40, 8'h41, 8'h42);
    insn_boundary = 1'b0; entry_req = 1'b1; entry_nmi = 1'b0;
    sp0 = sp; base = wn;
    @(negedge clk);
    entry_req = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!busy && !mem_we && !mem_re, "R2 no access before boundary",
          {busy, mem_we, mem_re}, 3'b000);
    end
    insn_boundary = 1'b1;
    @(negedge clk);
    chk(busy && mem_we, "R2 start after boundary", {busy, mem_we}, 2'b11);
    wait_done(n);
    check_entry(sp0, base, 1'b0);
    do_return();

    // R9 / R10 / R11: second request, pointer load and input change mid-frame
    @(negedge clk);
    set_ctx(16'hA001, 16'hA002, 16'hA003, 8'hA4, 8'hA5, 8'h01);
    push_saved(16'hA001, 16'hA002, 16'hA003, 8'hA4, 8'hA5, 8'h01);
    insn_boundary = 1'b1; entry_req = 1'b1; entry_nmi = 1'b0;
    sp0 = sp; base = wn;
    @(negedge clk);
    entry_req = 1'b0;
    repeat (2) @(negedge clk);
    set_ctx(16'hB001, 16'hB002, 16'hB003, 8'hB4, 8'hB5, 8'h02);
    entry_req = 1'b1; entry_nmi = 1'b1; sp_load = 1'b1; sp_load_val = 16'h0000;
    @(negedge clk);
    entry_req = 1'b0; entry_nmi = 1'b0; sp_load = 1'b0;
    wait_done(n);
    chk(sp == sp0 - 16'd9, "R11 sp_load ignored while busy", sp, sp0 - 16'd9);
    check_entry(sp0, base, 1'b0);
    push_saved(16'hB001, 16'hB002, 16'hB003, 8'hB4, 8'hB5, 8'h02);
    sp0 = sp; base = wn;
    wait_done(n);
    chk(n == 11, "R9 held entry latency", n, 11);
    check_entry(sp0, base, 1'b1);
    do_return();
    do_return();

    // Seeded random entries, some nested
    for (int it = 0; it < 25; it++) begin
      load_sp(16'h3C60 + 16'($urandom_range(0, 96)));
      nmi  = 1'($urandom);
      nest = 1'($urandom);
      do_entry(16'($urandom), 16'($urandom), 16'($urandom), 8'($urandom),
               8'($urandom), 8'($urandom), nmi);
      if (nest) begin
        do_entry(16'($urandom), 16'($urandom), 16'($urandom), 8'($urandom),
                 8'($urandom), 8'($urandom), ~nmi);
        do_return();
      end
      do_return();
    end

    chk(both_cnt == 0, "R11 read and write never together", both_cnt, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule